// File: doc/BRIEF.md
# Clock Interrupt Status Register

This block holds the interrupt bookkeeping of a real-time-clock style peripheral. Three single-cycle event strobes arrive from elsewhere in the chip: a periodic tick from the chosen divider tap, an alarm-match pulse and an update-done pulse. Each strobe sets its own sticky flag, whatever the state of the matching enable. A summary request bit is high whenever some flag and its enable are both set, and the active-low interrupt pin follows that summary bit.

A bus read of the status byte returns the summary bit and the three flags. The same read clears every flag. A second byte is read-only. Its top bit reflects a backup-supply-valid input, and reset does not touch it. Writes to either byte are accepted on the bus and then dropped.

Top module: `clk_irq_status`

## Requirements
- R1: An event strobe sets its flag on the next clock edge, whether or not its enable is set. Flag positions in the status byte (select 0): periodic at bit 6, alarm at bit 5, update at bit 4.
- R2: A set flag stays set until a status read or a reset.
- R3: Bit 7 of the status byte is the summary: it is 1 when periodic flag and periodic enable, alarm flag and alarm enable, or update flag and update enable are both 1. It follows enable changes with no delay.
- R4: `irq_n` is 0 exactly while the summary is 1.
- R5: A read (`bus_rd` high) with `bus_sel` = 0 puts the pre-clear status byte on `bus_rdata` one edge later and clears all flags on that same edge.
- R6: A strobe in the same cycle as a clearing read leaves its flag set after the edge.
- R7: Bits 3..0 of the status byte read 0. A write (`bus_wr` high, any `bus_wdata`, either select) changes no bit of either byte.
- R8: A read with `bus_sel` = 1 returns `supply_ok` in bit 7 and 0 in bits 6..0, and clears no flag.
- R9: A synchronous active-high reset clears all flags and `bus_rdata`. The supply bit still reflects `supply_ok` on the next read.
- R10: `bus_rdata` holds its value in cycles without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_periodic | input | 1 | Periodic tick strobe |
| ev_alarm | input | 1 | Alarm match strobe |
| ev_update | input | 1 | Update-ended strobe |
| en_periodic | input | 1 | Periodic interrupt enable |
| en_alarm | input | 1 | Alarm interrupt enable |
| en_update | input | 1 | Update interrupt enable |
| supply_ok | input | 1 | Backup supply valid indication |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe (ignored) |
| bus_sel | input | 1 | 0 = status byte, 1 = supply byte |
| bus_wdata | input | DW | Write data (ignored) |
| bus_rdata | output | DW | Registered read data |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The bench builds the block with its default byte width of 8. With that width the flag positions (6..4) and the always-zero low nibble are the ones the requirements state. At this width a random mix of strobes, enables, reads, writes and selects also reaches every flag/enable combination, as well as coincident strobe-and-read cycles, within a few thousand cycles.

// File: rtl/clk_irq_pkg.sv
package clk_irq_pkg;
    localparam int NSRC = 3;

    typedef enum logic {
        SEL_STATUS = 1'b0,
        SEL_SUPPLY = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic periodic;
        logic alarm;
        logic update;
    } src_vec_t;

    function automatic logic any_pair(src_vec_t f, src_vec_t e);
        return |(f & e);
    endfunction
endpackage

// File: rtl/irq_src_flag.sv
module irq_src_flag (
    input  logic clk,
    input  logic rst,
    input  logic ev,
    input  logic clr,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst)      flag <= 1'b0;
        else if (ev)  flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end

    p_set_r1:  assert property (@(posedge clk) disable iff (rst) ev |=> flag);
    p_hold_r2: assert property (@(posedge clk) disable iff (rst) (flag && !clr) |=> flag);
    p_clr_r5:  assert property (@(posedge clk) disable iff (rst) (clr && !ev) |=> !flag);
endmodule

// File: rtl/irq_summary.sv
module irq_summary
    import clk_irq_pkg::*;
(
    input  src_vec_t flags,
    input  src_vec_t enables,
    output logic     req,
    output logic     irq_n
);
    always_comb begin
        req   = any_pair(flags, enables);
        irq_n = ~req;
    end
endmodule

// File: rtl/irq_bus_port.sv
module irq_bus_port
    import clk_irq_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd,
    input  reg_sel_e      sel,
    input  logic          req,
    input  src_vec_t      flags,
    input  logic          supply_ok,
    output logic          clr,
    output logic [DW-1:0] rdata
);
    localparam int FLAG_HI = DW - 2;
    localparam int FLAG_LO = DW - 1 - NSRC;

    logic [DW-1:0] rd_byte;

    always_comb begin
        rd_byte = '0;
        if (sel == SEL_STATUS) begin
            rd_byte[DW-1]            = req;
            rd_byte[FLAG_HI:FLAG_LO] = flags;
        end else begin
            rd_byte[DW-1] = supply_ok;
        end
        clr = rd && (sel == SEL_STATUS);
    end

    always_ff @(posedge clk) begin
        if (rst)     rdata <= '0;
        else if (rd) rdata <= rd_byte;
    end

    p_low_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (rd && sel == SEL_STATUS) |=> rdata[FLAG_LO-1:0] == '0);
    p_supply_r8:   assert property (@(posedge clk) disable iff (rst)
        (rd && sel == SEL_SUPPLY) |=> (rdata[DW-1] == $past(supply_ok)) && (rdata[DW-2:0] == '0));
    p_hold_r10:    assert property (@(posedge clk) disable iff (rst)
        !rd |=> $stable(rdata));
endmodule

// File: rtl/clk_irq_status.sv
module clk_irq_status
    import clk_irq_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ev_periodic,
    input  logic          ev_alarm,
    input  logic          ev_update,
    input  logic          en_periodic,
    input  logic          en_alarm,
    input  logic          en_update,
    input  logic          supply_ok,
    input  logic          bus_rd,
    input  logic          bus_wr,
    input  logic          bus_sel,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          irq_n
);
    src_vec_t ev, en, flags;
    logic     clr, req;
    reg_sel_e sel;

    assign ev  = '{periodic: ev_periodic, alarm: ev_alarm, update: ev_update};
    assign en  = '{periodic: en_periodic, alarm: en_alarm, update: en_update};
    assign sel = reg_sel_e'(bus_sel);

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        irq_src_flag u_flag (
            .clk  (clk),
            .rst  (rst),
            .ev   (ev[i]),
            .clr  (clr),
            .flag (flags[i])
        );
    end

    irq_summary u_sum (
        .flags   (flags),
        .enables (en),
        .req     (req),
        .irq_n   (irq_n)
    );

    irq_bus_port #(.DW(DW)) u_bus (
        .clk       (clk),
        .rst       (rst),
        .rd        (bus_rd),
        .sel       (sel),
        .req       (req),
        .flags     (flags),
        .supply_ok (supply_ok),
        .clr       (clr),
        .rdata     (bus_rdata)
    );

    p_pin_r4: assert property (@(posedge clk) disable iff (rst)
        (|(flags & en)) == !irq_n);
    p_wr_r7:  assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_wdata != '0 && !bus_rd && ev == '0) |=> flags == $past(flags));
    p_keep_r6: assert property (@(posedge clk) disable iff (rst)
        (clr && ev != '0) |=> (flags & $past(ev)) == $past(ev));
endmodule

// File: tb/clk_irq_status_bench.sv
module clk_irq_status_bench;
    localparam int DW = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ev_p = 0, ev_a = 0, ev_u = 0;
    logic en_p = 0, en_a = 0, en_u = 0;
    logic supply_ok = 1'b1;
    logic bus_rd = 0, bus_wr = 0, bus_sel = 0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic irq_n;

    int checks = 0;
    int errors = 0;

    logic [2:0]    m_flags = '0;
    logic [DW-1:0] m_rdata = '0;

    always #10 clk = ~clk;

    clk_irq_status #(.DW(DW)) u_clk_irq_status (
        .clk(clk), .rst(rst),
        .ev_periodic(ev_p), .ev_alarm(ev_a), .ev_update(ev_u),
        .en_periodic(en_p), .en_alarm(en_a), .en_update(en_u),
        .supply_ok(supply_ok), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_sel(bus_sel), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_n(irq_n)
    );

    function automatic logic exp_req(logic [2:0] f, logic [2:0] e);
        return |(f & e);
    endfunction

    function automatic logic [DW-1:0] exp_byte(logic sel, logic [2:0] f, logic [2:0] e, logic sup);
        logic [DW-1:0] b = '0;
        if (!sel) begin
            b[7]   = exp_req(f, e);
            b[6:4] = f;
        end else begin
            b[7] = sup;
        end
        return b;
    endfunction

    task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Advance one edge: model the next state from inputs driven now.
    task automatic step();
        logic [2:0] ev = {ev_p, ev_a, ev_u};
        logic [2:0] en = {en_p, en_a, en_u};
        if (rst) begin
            m_flags = '0;
            m_rdata = '0;
        end else begin
            if (bus_rd) m_rdata = exp_byte(bus_sel, m_flags, en, supply_ok);
            if (bus_rd && !bus_sel) m_flags = '0;
            m_flags = m_flags | ev;
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_all(string tag);
        chk({tag, " R4 irq_n"}, {7'b0, irq_n},
            {7'b0, !exp_req(m_flags, {en_p, en_a, en_u})});
        chk({tag, " R10 rdata"}, bus_rdata, m_rdata);
    endtask

    task automatic idle();
        {ev_p, ev_a, ev_u} = '0;
        bus_rd = 0; bus_wr = 0; bus_sel = 0; bus_wdata = '0;
    endtask

    task automatic read(logic sel);
        bus_rd = 1; bus_sel = sel;
        step();
        bus_rd = 0;
    endtask

    initial begin
        #4_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        rst = 1; step(); step();
        rst = 0;
        check_all("R9 reset");
        chk("R9 rdata zero", bus_rdata, '0);

        // R1: flags set with enables off; status byte layout
        ev_p = 1; step(); idle();
        ev_a = 1; step(); idle();
        chk("R1 no irq with enables off", {7'b0, irq_n}, 8'h01);
        read(0);
        chk("R1 R7 status layout", bus_rdata, 8'h60);
        // R5: flags cleared by that read
        read(0);
        chk("R5 cleared after read", bus_rdata, 8'h00);

        // R3: enable change reflects immediately
        ev_u = 1; step(); idle();
        en_u = 1; #1;
        chk("R3 enable raises irq", {7'b0, irq_n}, 8'h00);
        en_u = 0; #1;
        chk("R3 enable drops irq", {7'b0, irq_n}, 8'h01);
        en_u = 1;

        // R6: strobe coinciding with clearing read
        ev_a = 1; bus_rd = 1; bus_sel = 0; step(); idle();
        chk("R6 read data pre-clear", bus_rdata, 8'h90);
        read(0);
        chk("R6 alarm kept", bus_rdata, 8'h20);

        // R7: writes ignored
        ev_p = 1; step(); idle();
        bus_wr = 1; bus_wdata = 8'hFF; bus_sel = 0; step();
        bus_sel = 1; step(); idle();
        read(0);
        chk("R7 write ignored", bus_rdata, 8'h40);

        // R8: supply byte, no clear, pin driven low
        ev_u = 1; step(); idle();
        supply_ok = 0;
        read(1);
        chk("R8 supply low", bus_rdata, 8'h00);
        supply_ok = 1;
        read(1);
        chk("R8 supply high", bus_rdata, 8'h80);
        read(0);
        chk("R8 flags survive supply read", bus_rdata, 8'h90);

        // R9: reset does not hide supply bit
        ev_p = 1; step(); idle();
        rst = 1; step(); rst = 0;
        chk("R9 irq released", {7'b0, irq_n}, 8'h01);
        read(1);
        chk("R9 supply after reset", bus_rdata, 8'h80);
        read(0);
        chk("R9 flags cleared", bus_rdata, 8'h00);

        // Random mix checked against the model (R1 R2 R3 R5 R6 R7 R8 R10)
        void'($urandom(32'd1234));
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] r = $urandom();
            ev_p = (r[3:0] == 0); ev_a = (r[7:4] == 0); ev_u = (r[11:8] == 0);
            if (r[15:12] == 0) {en_p, en_a, en_u} = r[18:16];
            bus_rd = (r[21:19] == 0); bus_sel = r[22];
            bus_wr = (r[25:23] == 0); bus_wdata = r[31:24];
            supply_ok = (r[30:28] != 0);
            #1;
            chk("R3 R4 random irq", {7'b0, irq_n}, {7'b0, !exp_req(m_flags, {en_p, en_a, en_u})});
            step();
            chk("R2 R5 R8 R10 random rdata", bus_rdata, m_rdata);
        end
        idle();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule